// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host read and write a small register file over a four-wire serial link: a serial clock, an active-low chip select, a data input and a data output that can be tri-stated. While chip select is low, the block shifts in one bit of the data input on every rising edge of the serial clock. When chip select rises, the block classifies the frame by the number of bits it received. It accepts data-only frames of 8 bits and addressed frames of 16 or 24 bits, and it drops any other length. The first bit of an addressed frame chooses the operation: 0 writes and 1 reads.

A write produces a one-cycle strobe with an address, a page nibble and a data byte on the register-file side. A read selects a register address and pulses a read enable. The block captures the byte that the register file returns. Once chip select is high, the block drives that byte on the data output over eight serial clock periods, most significant bit first. Outside that phase the output enable stays low.

The serial pins are synchronised into the system clock domain, and all edge detection runs on that clock.

Top module: `serial_reg_slave`

## Requirements
- R1: A 16-bit frame (bit count 16 at chip-select rise, first bit 0) produces exactly one write strobe. The address is frame bits 11..8, the data is bits 7..0 and the page is 0. Frames are shifted in most significant bit first.
- R2: A 24-bit frame with bit 23 = 0 writes. Bits 11..8 give the register address, bits 15..12 appear as the page and bits 7..0 are the data. Bits 22..16 have no effect.
- R3: An 8-bit frame writes its byte to the address and page of the most recent 16- or 24-bit write frame. If no such frame has arrived since reset, the 8-bit frame causes no strobe.
- R4: A write addressed to register 0 produces no write strobe.
- R5: A frame of any length other than 8, 16 or 24 bits causes no write strobe and no read-back. It also leaves the address that later 8-bit frames use unchanged.
- R6: A 16- or 24-bit frame whose first bit is 1 reads. It produces no write strobe and one read-enable pulse with the address from bits 11..8. Its low eight bits have no effect.
- R7: After a read frame the output enable goes high with bit 7 of the read byte on the data output. The first serial clock fall after chip select rises does not advance the output. Each later fall that follows a rise moves to the next lower bit.
- R8: The output enable drops on the serial clock fall that follows the eighth read-back rise.
- R9: A read of a register with address bit 3 set (0x8 to 0xF) starts a read-back only when the device address input is 0. Otherwise the read enable does not pulse and the output enable stays low.
- R10: Chip select going low ends any read-back, and the output enable stays low while chip select is low.
- R11: After reset the output enable, the write strobe and the read enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial read-back data |
| dout_oe | output | 1 | Output enable for dout (low = tri-state) |
| drv_addr | input | DRV_W | This device's position address |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 4 | Register address of the write |
| reg_wr_page | output | 4 | Upper nibble of a 24-bit address byte |
| reg_wr_data | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle register read enable |
| reg_rd_addr | output | 4 | Register address of the read (held) |
| reg_rd_data | input | 8 | Read data, valid in the reg_rd_en cycle |

## Verification
The bench targets these corner cases:

- **First fall after chip select rises.** A design that advanced the output on this fall would return a byte shifted by one bit.
- **Frames of wrong length.** A design that miscounted would write garbage or start a spurious read-back.
- **8-bit frame sent before any address.** A design that ignored this case would write to register 0.
- **Global register read on a non-zero device.** A design that skipped this check would fight other devices on the shared output.
- **Read-back cut short by a new frame.** A design that failed to drop the enable here would drive the output during a host write.

// File: rtl/sras_pkg.sv
package sras_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int PAGE_W     = 4;
    localparam int LEN_SHORT  = 8;
    localparam int LEN_MID    = 16;
    localparam int LEN_LONG   = 24;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_SHORT = 2'd1,
        FK_MID   = 2'd2,
        FK_LONG  = 2'd3
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e       kind;
        logic              rd;
        logic [PAGE_W-1:0] page;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic frame_kind_e classify(input logic [31:0] nbits);
        case (nbits)
            32'(LEN_SHORT): return FK_SHORT;
            32'(LEN_MID):   return FK_MID;
            32'(LEN_LONG):  return FK_LONG;
            default:        return FK_NONE;
        endcase
    endfunction

    // Upper half of the register space is shared across the chain.
    function automatic logic is_global(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

endpackage

// File: rtl/sras_sync.sv
module sras_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= {STAGES{RST_VAL}};
                end else begin
                    chain[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        chain[i] <= chain[i-1];
                    end
                end
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sras_rx.sv
module sras_rx
    import sras_pkg::*;
#(
    parameter int FRAME_MAX = LEN_LONG
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n_s,
    input  logic   cs_rise,
    input  logic   sclk_rise,
    input  logic   din_s,
    output logic   frm_valid,
    output frame_t frm
);
    localparam int CNT_SAT = FRAME_MAX + 1;
    localparam int CNT_W   = $clog2(FRAME_MAX + 2);

    logic [FRAME_MAX-1:0] shreg;
    logic [CNT_W-1:0]     cnt;
    frame_t               nxt;

    always_comb begin
        nxt      = '0;
        nxt.kind = classify(32'(cnt));
        case (nxt.kind)
            FK_SHORT: nxt.data = shreg[DATA_W-1:0];
            FK_MID: begin
                nxt.rd   = shreg[LEN_MID-1];
                nxt.addr = shreg[DATA_W +: ADDR_W];
                nxt.data = shreg[DATA_W-1:0];
            end
            FK_LONG: begin
                nxt.rd   = shreg[LEN_LONG-1];
                nxt.page = shreg[DATA_W+ADDR_W +: PAGE_W];
                nxt.addr = shreg[DATA_W +: ADDR_W];
                nxt.data = shreg[DATA_W-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            cnt       <= '0;
            frm_valid <= 1'b0;
            frm       <= '0;
        end else begin
            frm_valid <= 1'b0;
            if (!cs_n_s) begin
                if (sclk_rise) begin
                    shreg <= {shreg[FRAME_MAX-2:0], din_s};
                    if (cnt != CNT_W'(CNT_SAT)) cnt <= cnt + 1'b1;
                end
            end else begin
                if (cs_rise) begin
                    frm_valid <= (nxt.kind != FK_NONE);
                    frm       <= nxt;
                end
                cnt <= '0;
            end
        end
    end

    // R5: a frame is only ever reported at the end of a select window
    p_frame_at_cs_rise_r5: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> $past(cs_rise));
endmodule

// File: rtl/sras_decode.sv
module sras_decode
    import sras_pkg::*;
#(
    parameter int DRV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  frame_t            frm,
    input  logic [DRV_W-1:0]  drv_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PAGE_W-1:0] wr_page,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [ADDR_W-1:0] last_addr;
    logic [PAGE_W-1:0] last_page;
    logic              may_drive;

    assign may_drive = !is_global(frm.addr) || (drv_addr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_page   <= '0;
            wr_data   <= '0;
            rd_en     <= 1'b0;
            rd_addr   <= '0;
            last_addr <= '0;
            last_page <= '0;
        end else begin
            wr_en <= 1'b0;
            rd_en <= 1'b0;
            if (frm_valid) begin
                case (frm.kind)
                    FK_SHORT: begin
                        if (last_addr != '0) begin
                            wr_en   <= 1'b1;
                            wr_addr <= last_addr;
                            wr_page <= last_page;
                            wr_data <= frm.data;
                        end
                    end
                    FK_MID, FK_LONG: begin
                        if (frm.rd) begin
                            if (may_drive) begin
                                rd_en   <= 1'b1;
                                rd_addr <= frm.addr;
                            end
                        end else begin
                            last_addr <= frm.addr;
                            last_page <= frm.page;
                            if (frm.addr != '0) begin
                                wr_en   <= 1'b1;
                                wr_addr <= frm.addr;
                                wr_page <= frm.page;
                                wr_data <= frm.data;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: the read-only register never sees a strobe
    p_no_write_reg0_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr != '0));
    // R6: one frame never both writes and reads
    p_rd_wr_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en));
    // R9: shared registers are only read back by device 0
    p_global_gate_r9: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (!is_global(rd_addr) || ($past(drv_addr) == '0)));
    // R1: a strobe follows a decoded frame
    p_wr_needs_frame_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(frm_valid));
endmodule

// File: rtl/sras_tx.sv
module sras_tx
    import sras_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              dout,
    output logic              dout_oe
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              seen_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            idx       <= '0;
            seen_rise <= 1'b0;
            dout_oe   <= 1'b0;
        end else if (!cs_n_s) begin
            dout_oe   <= 1'b0;
            seen_rise <= 1'b0;
        end else if (load) begin
            shreg     <= load_data;
            idx       <= '0;
            seen_rise <= 1'b0;
            dout_oe   <= 1'b1;
        end else if (dout_oe) begin
            if (sclk_rise) begin
                seen_rise <= 1'b1;
            end else if (sclk_fall && seen_rise) begin
                seen_rise <= 1'b0;
                if (idx == IDX_W'(DATA_W - 1)) begin
                    dout_oe <= 1'b0;
                end else begin
                    idx   <= idx + 1'b1;
                    shreg <= {shreg[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign dout = dout_oe ? shreg[DATA_W-1] : 1'b0;

    // R10: select low silences the output on the next cycle
    p_quiet_when_selected_r10: assert property (@(posedge clk) disable iff (rst)
        !cs_n_s |=> !dout_oe);
    // R7: read-back opens with the top bit of the captured byte
    p_first_bit_msb_r7: assert property (@(posedge clk) disable iff (rst)
        (load && cs_n_s) |=> (dout_oe && (dout == $past(load_data[DATA_W-1]))));
    // R7: the output bit only moves on a serial clock fall
    p_move_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && $past(dout_oe) && !$past(sclk_fall)) |-> $stable(dout));
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
    import sras_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_MAX   = LEN_LONG,
    parameter int DRV_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    input  logic [DRV_W-1:0]  drv_addr,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [PAGE_W-1:0] reg_wr_page,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data
);
    logic   sclk_s, cs_n_s, din_s;
    logic   sclk_q, cs_q;
    logic   sclk_rise, sclk_fall, cs_rise;
    logic   frm_valid;
    frame_t frm;

    sras_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk (
        .clk(clk), .rst(rst), .d(sclk), .q(sclk_s));
    sras_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
        .clk(clk), .rst(rst), .d(cs_n), .q(cs_n_s));
    sras_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_din (
        .clk(clk), .rst(rst), .d(din), .q(din_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_rise   = cs_n_s & ~cs_q;

    sras_rx #(.FRAME_MAX(FRAME_MAX)) i_rx (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .din_s(din_s),
        .frm_valid(frm_valid), .frm(frm));

    sras_decode #(.DRV_W(DRV_W)) i_dec (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm(frm),
        .drv_addr(drv_addr),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_page(reg_wr_page),
        .wr_data(reg_wr_data), .rd_en(reg_rd_en), .rd_addr(reg_rd_addr));

    sras_tx i_tx (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .load(reg_rd_en), .load_data(reg_rd_data),
        .dout(dout), .dout_oe(dout_oe));
endmodule

// File: tb/test_serial_reg_slave.sv
module test_serial_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
    logic       dout, dout_oe;
    logic [7:0] drv_addr = 8'd0;
    logic       reg_wr_en, reg_rd_en;
    logic [3:0] reg_wr_addr, reg_wr_page, reg_rd_addr;
    logic [7:0] reg_wr_data, reg_rd_data;

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [3:0] last_wa, last_wp;
    logic [7:0] last_wd;
    int  cs_low_cyc = 0;
    logic bad_oe = 1'b0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign reg_rd_data = {reg_rd_addr, ~reg_rd_addr};

    serial_reg_slave i_serial_reg_slave (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .drv_addr(drv_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_page(reg_wr_page), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data));

    always @(posedge clk) begin
        if (!rst) begin
            if (reg_wr_en) begin
                wr_cnt  <= wr_cnt + 1;
                last_wa <= reg_wr_addr;
                last_wp <= reg_wr_page;
                last_wd <= reg_wr_data;
            end
            if (reg_rd_en) rd_cnt <= rd_cnt + 1;
            cs_low_cyc <= cs_n ? 0 : cs_low_cyc + 1;
            if (!cs_n && cs_low_cyc > 4 && dout_oe) bad_oe <= 1'b1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int nbits, input logic [31:0] val);
        cs_n = 1'b0;
        wclk(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            sclk = 1'b0; din = val[i];
            wclk(HALF);
            sclk = 1'b1;
            wclk(HALF);
        end
        cs_n = 1'b1;
        wclk(HALF);
        sclk = 1'b0;
        wclk(HALF);
    endtask

    task automatic read_back(input string req, input logic [7:0] exp);
        for (int i = 7; i >= 0; i--) begin
            chk(req, "oe during read-back", int'(dout_oe), 1);
            chk(req, "read-back bit", int'(dout), int'(exp[i]));
            sclk = 1'b1; wclk(HALF);
            sclk = 1'b0; wclk(HALF);
        end
        chk("R8", "oe after eighth bit", int'(dout_oe), 0);
    endtask

    task automatic t_reset();
        chk("R11", "oe after reset", int'(dout_oe), 0);
        chk("R11", "wr strobe after reset", int'(reg_wr_en), 0);
        chk("R11", "rd enable after reset", int'(reg_rd_en), 0);
    endtask

    task automatic t_short_first();
        int w0 = wr_cnt;
        send_frame(8, 32'hAB);
        chk("R3", "8-bit frame before any address", wr_cnt - w0, 0);
    endtask

    task automatic t_write16();
        int w0 = wr_cnt;
        send_frame(16, 32'h0312);
        chk("R1", "strobe count", wr_cnt - w0, 1);
        chk("R1", "addr", int'(last_wa), 3);
        chk("R1", "data", int'(last_wd), 8'h12);
        chk("R1", "page", int'(last_wp), 0);
    endtask

    task automatic t_write24();
        int w0 = wr_cnt;
        send_frame(24, 32'h7FA75C);
        chk("R2", "strobe count", wr_cnt - w0, 1);
        chk("R2", "addr", int'(last_wa), 7);
        chk("R2", "page", int'(last_wp), 4'hA);
        chk("R2", "data", int'(last_wd), 8'h5C);
    endtask

    task automatic t_short_follow();
        int w0 = wr_cnt;
        send_frame(8, 32'h99);
        chk("R3", "strobe count", wr_cnt - w0, 1);
        chk("R3", "addr reused", int'(last_wa), 7);
        chk("R3", "page reused", int'(last_wp), 4'hA);
        chk("R3", "data", int'(last_wd), 8'h99);
    endtask

    task automatic t_write_zero();
        int w0 = wr_cnt;
        send_frame(16, 32'h0077);
        chk("R4", "write to reg 0", wr_cnt - w0, 0);
        send_frame(8, 32'h11);
        chk("R4", "8-bit after reg 0 write", wr_cnt - w0, 0);
    endtask

    task automatic t_bad_len();
        int w0;
        send_frame(16, 32'h0312);
        w0 = wr_cnt;
        send_frame(12, 32'h0A55);
        chk("R5", "12-bit frame strobe", wr_cnt - w0, 0);
        chk("R5", "12-bit frame oe", int'(dout_oe), 0);
        send_frame(20, 32'h80B00);
        chk("R5", "20-bit frame strobe", wr_cnt - w0, 0);
        chk("R5", "20-bit frame oe", int'(dout_oe), 0);
        send_frame(8, 32'h66);
        chk("R5", "address kept", int'(last_wa), 3);
        chk("R5", "data of 8-bit", int'(last_wd), 8'h66);
    endtask

    task automatic t_read16();
        int w0 = wr_cnt, r0 = rd_cnt;
        drv_addr = 8'd0;
        send_frame(16, 32'h85FF);
        chk("R6", "no write on read", wr_cnt - w0, 0);
        chk("R6", "one read enable", rd_cnt - r0, 1);
        read_back("R7", 8'h5A);
    endtask

    task automatic t_read24_global();
        drv_addr = 8'd0;
        send_frame(24, 32'h800B00);
        read_back("R9", 8'hB4);
    endtask

    task automatic t_global_other();
        int r0 = rd_cnt;
        drv_addr = 8'd3;
        send_frame(24, 32'h800B00);
        chk("R9", "no read enable", rd_cnt - r0, 0);
        chk("R9", "oe stays low", int'(dout_oe), 0);
        send_frame(16, 32'h8500);
        read_back("R9", 8'h5A);
        drv_addr = 8'd0;
    endtask

    task automatic t_abort();
        send_frame(16, 32'h8300);
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; wclk(HALF);
            sclk = 1'b0; wclk(HALF);
        end
        chk("R10", "oe before abort", int'(dout_oe), 1);
        bad_oe = 1'b0;
        send_frame(16, 32'h0444);
        chk("R10", "oe while selected", int'(bad_oe), 0);
        chk("R10", "oe after abort", int'(dout_oe), 0);
        chk("R10", "new frame addr", int'(last_wa), 4);
        chk("R10", "new frame data", int'(last_wd), 8'h44);
    endtask

    initial begin
        wclk(5);
        rst = 1'b0;
        wclk(5);
        t_reset();
        t_short_first();
        t_write16();
        t_write24();
        t_short_follow();
        t_write_zero();
        t_bad_len();
        t_read16();
        t_read24_global();
        t_global_other();
        t_abort();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule